// File: doc/BRIEF.md
# Serial Bit-Rate Configuration Controller

This block sits between a host serial port and an infrared pulse encoder/decoder. It owns the configuration of that path: the active bit rate, the transmit pulse-width mode and two general-purpose control outputs. From the system clock it derives a one-cycle enable tick at sixteen times the active bit rate. The encoder and decoder logic use this tick for their timing.

Configuration arrives in-band. While the program pin is high, the serial line carries one asynchronous control character: 8 data bits, no parity, 1 stop bit, least significant bit first. The block receives it at the bit rate that is already active. The settings are held back until the program pin goes low again, and only then do they replace the working configuration. A transceiver power-enable output follows the reset input, so the optical front end is held off for as long as the block is in reset.

Top module: `sir_rate_cfg`

## Requirements
- R1: While reset is asserted and after it is released, the tick period is 24 clock cycles (code 6, 9600 bit/s at a 3.6864 MHz clock), `short_pulse_o` is 1 and `user_o` is 00.
- R2: `xcvr_pwr_o` is low exactly while `rst_ni` is low, and high otherwise.
- R3: `tick16_o` is a single-cycle pulse. Its period in clock cycles is set by the rate code: 0→2, 1→4, 2→6, 3→12, 4→16, 5→18, 6→24, 7→32, 8→48, 9→64, A→96, B→128, C→192.
- R4: Characters are received only while `prog_i` is high. Each character is 8N1, LSB first, with 16 ticks per bit at the active rate, and each bit is sampled at tick 8 of its 16. A character sent while `prog_i` is low has no effect.
- R5: The received byte is decoded as follows. Bits 3:0 are the rate code. Bit 4 sets `short_pulse_o` (1 = fixed short pulse, 0 = 3/16-bit pulse). Bit 5 drives `user_o[0]` and bit 6 drives `user_o[1]`. Bit 7 is ignored.
- R6: The outputs and the tick period keep their previous values while `prog_i` stays high. A valid pending character takes effect within 8 clock cycles after `prog_i` falls.
- R7: A rate code of D, E or F leaves the tick period unchanged. The pulse-mode and user bits of that character are still applied.
- R8: A character whose stop bit is sampled low is discarded.
- R9: A character that `prog_i` interrupts before its stop bit is discarded.
- R10: If several complete characters arrive in one high window of `prog_i`, the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, nominally 3.6864 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_i | input | 1 | Program pin: high = control character, low = data mode |
| ser_i | input | 1 | Serial transmit line from the host, idle high |
| tick16_o | output | 1 | One-cycle enable at 16x the active bit rate |
| short_pulse_o | output | 1 | 1 = fixed short pulse, 0 = 3/16-bit pulse |
| user_o | output | 2 | General-purpose control outputs |
| xcvr_pwr_o | output | 1 | Transceiver power enable, low during reset |

## Verification
A corrupted rate register shows up as a wrong tick period at the next tick, at most 192 cycles later. A corrupted pending or apply path shows up only when `prog_i` falls, as pulse-mode or user bits that differ from the last good character. For that reason every test programs a distinct pattern and then measures all outputs after the fall. Receiver framing faults, such as a wrong sample point, a lost bit or a dropped stop check, change the decoded fields and show up one character later.

// File: rtl/sir_rate_pkg.sv
package sir_rate_pkg;
  localparam int unsigned NUM_RATES = 13;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(6);

  typedef struct packed {
    logic [CODE_W-1:0] rate;
    logic              short_pulse;
    logic [1:0]        user;
  } cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
  } rx_state_e;

  // clocks per 16x tick at 3.6864 MHz
  function automatic logic [DIV_W-1:0] rate_div(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    rate_div = 8'd2;
      4'd1:    rate_div = 8'd4;
      4'd2:    rate_div = 8'd6;
      4'd3:    rate_div = 8'd12;
      4'd4:    rate_div = 8'd16;
      4'd5:    rate_div = 8'd18;
      4'd6:    rate_div = 8'd24;
      4'd7:    rate_div = 8'd32;
      4'd8:    rate_div = 8'd48;
      4'd9:    rate_div = 8'd64;
      4'd10:   rate_div = 8'd96;
      4'd11:   rate_div = 8'd128;
      4'd12:   rate_div = 8'd192;
      default: rate_div = 8'd24;
    endcase
  endfunction
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sir_tick_gen.sv
module sir_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= keeps the counter bounded if the divisor shrinks
  assign wrap = (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (wrap)      cnt_q <= '0;
    else                cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = wrap & ~restart_i;
endmodule

// File: rtl/sir_ctrl_rx.sv
module sir_ctrl_rx
  import sir_rate_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 rxd_i,
  output logic                 busy_o,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BLAST = BIT_W'(DATA_BITS - 1);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     tcnt_q;
  logic [BIT_W-1:0]     bcnt_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!rxd_i) begin
            state_q <= RX_START;
            tcnt_q  <= CNT_W'(1);
          end
          RX_START: begin
            if (tcnt_q == MID) begin
              tcnt_q  <= '0;
              bcnt_q  <= '0;
              state_q <= rxd_i ? RX_IDLE : RX_DATA;
            end else tcnt_q <= tcnt_q + CNT_W'(1);
          end
          RX_DATA: begin
            if (tcnt_q == LAST) begin
              tcnt_q <= '0;
              sh_q   <= {rxd_i, sh_q[DATA_BITS-1:1]};
              bcnt_q <= bcnt_q + BIT_W'(1);
              if (bcnt_q == BLAST) state_q <= RX_STOP;
            end else tcnt_q <= tcnt_q + CNT_W'(1);
          end
          RX_STOP: begin
            if (tcnt_q == LAST) begin
              tcnt_q  <= '0;
              valid_q <= rxd_i;
              state_q <= rxd_i ? RX_IDLE : RX_BREAK;
            end else tcnt_q <= tcnt_q + CNT_W'(1);
          end
          RX_BREAK: if (rxd_i) state_q <= RX_IDLE;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o  = (state_q != RX_IDLE);
  assign valid_o = valid_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/sir_cfg_regs.sv
module sir_cfg_regs
  import sir_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic              apply_o
);
  logic              prog_q;
  logic [BYTE_W-1:0] pend_q;
  logic              pend_vld_q;
  cfg_t              cfg_q;
  logic              apply_q;
  logic              rise, fall;

  assign rise = prog_i & ~prog_q;
  assign fall = ~prog_i & prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q           <= 1'b0;
      pend_q           <= '0;
      pend_vld_q       <= 1'b0;
      cfg_q.rate       <= RST_CODE;
      cfg_q.short_pulse <= 1'b1;
      cfg_q.user       <= 2'b00;
      apply_q          <= 1'b0;
    end else begin
      prog_q  <= prog_i;
      apply_q <= 1'b0;
      if (rise) pend_vld_q <= 1'b0;
      if (wr_i) begin
        pend_q     <= wr_data_i;
        pend_vld_q <= 1'b1;
      end
      if (fall && pend_vld_q) begin
        cfg_q.short_pulse <= pend_q[4];
        cfg_q.user        <= pend_q[6:5];
        if (pend_q[3:0] < CODE_W'(NUM_RATES)) cfg_q.rate <= pend_q[3:0];
        pend_vld_q <= 1'b0;
        apply_q    <= 1'b1;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign apply_o = apply_q;
endmodule

// File: rtl/sir_rate_cfg.sv
module sir_rate_cfg
  import sir_rate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVS         = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_i,
  input  logic       ser_i,
  output logic       tick16_o,
  output logic       short_pulse_o,
  output logic [1:0] user_o,
  output logic       xcvr_pwr_o
);
  logic              prog_s, ser_s;
  logic              rx_busy, rx_valid;
  logic [BYTE_W-1:0] rx_data;
  cfg_t              cfg_q;
  logic              apply;

  sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(prog_i), .q_o(prog_s));

  sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_i), .q_o(ser_s));

  sir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(apply),
    .div_i(rate_div(cfg_q.rate)), .tick_o(tick16_o));

  sir_ctrl_rx #(.OVS(OVS), .DATA_BITS(BYTE_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(prog_s), .tick_i(tick16_o),
    .rxd_i(ser_s), .busy_o(rx_busy), .valid_o(rx_valid), .data_o(rx_data));

  sir_cfg_regs u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_i(prog_s), .wr_i(rx_valid),
    .wr_data_i(rx_data), .cfg_o(cfg_q), .apply_o(apply));

  assign short_pulse_o = cfg_q.short_pulse;
  assign user_o        = cfg_q.user;
  assign xcvr_pwr_o    = rst_ni;
endmodule

// File: rtl/sir_rate_cfg_chk.sv
module sir_rate_cfg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_s,
  input logic       tick16_o,
  input logic       short_pulse_o,
  input logic [1:0] user_o,
  input logic       rx_busy,
  input logic       rx_valid,
  input logic [3:0] rate_code
);
  logic [9:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= '0;
    else if (tick16_o)  gap_q <= '0;
    else if (gap_q != 10'h3ff) gap_q <= gap_q + 10'd1;
  end

  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16_o |=> !tick16_o);

  a_r3_tick_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < 10'd400);

  a_r6_hold_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(prog_s) |-> ($stable(short_pulse_o) && $stable(user_o) && $stable(rate_code)));

  a_r4_rx_only_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |-> prog_s);

  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_s |=> !rx_busy);

  a_r7_rate_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_code <= 4'd12);
endmodule

bind sir_rate_cfg sir_rate_cfg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prog_s(prog_s), .tick16_o(tick16_o),
  .short_pulse_o(short_pulse_o), .user_o(user_o), .rx_busy(rx_busy),
  .rx_valid(rx_valid), .rate_code(cfg_q.rate));

// File: tb/tb_sir_rate_cfg.sv
`timescale 1ns/1ps
module tb_sir_rate_cfg;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic prog_i = 1'b0;
  logic ser_i = 1'b1;
  logic tick16_o, short_pulse_o, xcvr_pwr_o;
  logic [1:0] user_o;

  always #2 clk = ~clk;

  sir_rate_cfg dut (
    .clk_i(clk), .rst_ni(rst_ni), .prog_i(prog_i), .ser_i(ser_i),
    .tick16_o(tick16_o), .short_pulse_o(short_pulse_o), .user_o(user_o),
    .xcvr_pwr_o(xcvr_pwr_o));

  typedef struct {
    int       per;
    bit       sp;
    bit [1:0] usr;
    string    req;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, n_issued = 0, n_done = 0;
  int cur_div = 24;
  bit cur_sp = 1'b1;
  bit [1:0] cur_usr = 2'b00;

  function automatic int bps_of(input int code);
    case (code)
      0: return 115200;  1: return 57600;  2: return 38400;  3: return 19200;
      4: return 14400;   5: return 12800;  6: return 9600;   7: return 7200;
      8: return 4800;    9: return 3600;   10: return 2400;  11: return 1800;
      12: return 1200;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input bit [7:0] b, input bit stop);
    ser_i = 1'b0; hold(16*cur_div);
    for (int i = 0; i < 8; i++) begin ser_i = b[i]; hold(16*cur_div); end
    ser_i = stop; hold(16*cur_div);
    ser_i = 1'b1;
  endtask

  task automatic model_apply(input bit [7:0] b);
    if (b[3:0] < 4'd13) cur_div = 230400 / bps_of(int'(b[3:0]));
    cur_sp  = b[4];
    cur_usr = b[6:5];
  endtask

  task automatic expect_cfg(input string req);
    exp_t e;
    e.per = cur_div; e.sp = cur_sp; e.usr = cur_usr; e.req = req;
    n_issued++;
    exp_q.push_back(e);
    wait (n_done == n_issued);
  endtask

  task automatic program_char(input bit [7:0] b);
    prog_i = 1'b1; hold(16*cur_div);
    send_frame(b, 1'b1);
    hold(16*cur_div);
    prog_i = 1'b0; hold(8);
    model_apply(b);
  endtask

  // monitor: measure tick period and settings, compare against queue head
  initial begin
    forever begin
      exp_t e;
      int per;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      @(negedge clk);
      while (!tick16_o) @(negedge clk);
      per = 0;
      do begin @(negedge clk); per++; end while (!tick16_o);
      chk(per == e.per, e.req, "tick period", per, e.per);
      chk(short_pulse_o == e.sp, e.req, "pulse mode", int'(short_pulse_o), int'(e.sp));
      chk(user_o == e.usr, e.req, "user bits", int'(user_o), int'(e.usr));
      chk(xcvr_pwr_o == 1'b1, e.req, "xcvr power", int'(xcvr_pwr_o), 1);
      n_done++;
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    hold(3);
    // R2: power enable low in reset; R1: defaults visible during reset
    chk(xcvr_pwr_o == 1'b0, "R2", "xcvr in reset", int'(xcvr_pwr_o), 0);
    chk(short_pulse_o == 1'b1, "R1", "pulse in reset", int'(short_pulse_o), 1);
    chk(user_o == 2'b00, "R1", "user in reset", int'(user_o), 0);
    rst_ni = 1'b1; hold(4);
    chk(xcvr_pwr_o == 1'b1, "R2", "xcvr after reset", int'(xcvr_pwr_o), 1);
    expect_cfg("R1");

    program_char(8'h20);           // R3 code 0, R5 bit5 -> user[0]
    expect_cfg("R3");
    program_char(8'hDB);           // R5 bit7 ignored, bit6 -> user[1], code B
    expect_cfg("R5");
    program_char(8'h83);           // R3 code 3, short 0
    expect_cfg("R5");
    program_char(8'h7E);           // R7 code E keeps rate
    expect_cfg("R7");

    // R8: low stop bit discarded
    prog_i = 1'b1; hold(16*cur_div);
    send_frame(8'h05, 1'b0);
    hold(16*cur_div);
    prog_i = 1'b0; hold(8);
    expect_cfg("R8");

    // R9: abort mid-character
    prog_i = 1'b1; hold(16*cur_div);
    ser_i = 1'b0; hold(16*cur_div);
    for (int i = 0; i < 3; i++) begin ser_i = i[0]; hold(16*cur_div); end
    prog_i = 1'b0; ser_i = 1'b1; hold(16*cur_div);
    expect_cfg("R9");

    // R4: character in data mode has no effect
    send_frame(8'h00, 1'b1);
    hold(16*cur_div);
    expect_cfg("R4");

    // R6: held while prog high, applied after fall
    prog_i = 1'b1; hold(16*cur_div);
    send_frame(8'h05, 1'b1);
    hold(16*cur_div);
    expect_cfg("R6");
    prog_i = 1'b0; hold(8);
    model_apply(8'h05);
    expect_cfg("R6");

    // R10: last of two characters wins
    prog_i = 1'b1; hold(16*cur_div);
    send_frame(8'h0C, 1'b1);
    hold(16*cur_div);
    send_frame(8'h31, 1'b1);
    hold(16*cur_div);
    prog_i = 1'b0; hold(8);
    model_apply(8'h31);
    expect_cfg("R10");

    program_char(8'h4C);           // R3 slowest code C
    expect_cfg("R3");

    // R2/R1: reset mid-operation restores defaults
    rst_ni = 1'b0; hold(2);
    chk(xcvr_pwr_o == 1'b0, "R2", "xcvr in reset", int'(xcvr_pwr_o), 0);
    rst_ni = 1'b1; hold(4);
    cur_div = 24; cur_sp = 1'b1; cur_usr = 2'b00;
    expect_cfg("R1");

    summary();
    $finish;
  end
endmodule